// File: doc/BRIEF.md
# Buffered Modulus Counter Channel

This block is the counting engine of one timer channel. A counter of `CNT_W` bits (16 by default) steps between 1 and an active modulus. In up-only mode it climbs to the modulus and restarts at 1. In up/down mode it climbs to the modulus, turns, and descends to 1. Software never writes the active modulus directly. It writes a buffer register at any time, and the counter copies the buffer into the active modulus at the end of each counting cycle. A new period therefore always starts cleanly and never cuts a cycle short.

Each step is triggered by a tick. The tick comes from a prescaled clock-enable input or from an external pin. The pin passes through a synchroniser and an edge detector that reacts to the rising edge, the falling edge or both edges. A sticky cycle flag marks every cycle boundary and stays set until software clears it. While the channel is stopped, software can preload the counter. If the counter is started outside 1..modulus, it runs up to all-ones, wraps to 1 and then carries on normally.

Top module: `mcc_channel`

## Requirements
- R1: While running, the counter changes only on an accepted tick and never holds 0 once it holds a non-zero value.
- R2: Up-only mode (control bit 0 = 0): a tick with counter equal to the active modulus loads 1, so the count repeats every modulus ticks.
- R3: Up/down mode (control bit 0 = 1): a tick at the modulus reverses the direction to down. The count falls to 1 and then rises again, so the period is 2×modulus−2 ticks.
- R4: While running, the active modulus takes the buffer value (written at address 1) only on a cycle-boundary tick. A buffer write during one cycle first applies in the following cycle. While stopped, the active modulus follows the buffer.
- R5: A counter started above the modulus counts up to all-ones, then wraps to 1 without raising the flag, and then cycles normally.
- R6: Control bit 1 selects the tick source: 0 selects `presc_tick`, 1 selects the external pin. Pulses on the source that is not selected have no effect.
- R7: With the pin selected, control bit 3 = 1 counts rising edges and 0 counts falling edges. Control bit 2 = 1 counts both edges.
- R8: The flag is set at the clock edge that carries out a boundary tick. In up-only mode this is the modulus-to-1 step. In up/down mode it is the downward step that lands on 1. The flag is not set at any other time.
- R9: The flag holds until a write to address 2 with data bit 0 = 1. A write with bit 0 = 0 leaves it set. If a set and a clear fall in the same cycle, the flag stays set.
- R10: A write to address 3 loads the counter only while stopped (control bit 4 = 0). Such a write has no effect while running (control bit 4 = 1).
- R11: After reset the counter reads 1, the flag reads 0, the active and buffered modulus are all-ones and all control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 modulus buffer, 2 flag clear, 3 counter preload |
| wr_data | input | CNT_W | Write data |
| presc_tick | input | 1 | Prescaled internal clock enable |
| ext_pin | input | 1 | Asynchronous external tick pin |
| count_o | output | CNT_W | Current counter value |
| flag_o | output | 1 | Sticky cycle-boundary flag |

## Verification
Up-only counting is run with a small modulus over two full periods. The flag must appear exactly on the modulus-to-1 step and never one tick early. Up/down counting is checked step by step with modulus 3, which separates a correct 2×A−2 period from an off-by-one turn at either end. Further runs cover a buffer write in mid-cycle, a start above the modulus and a preload while running; these separate immediate reload from boundary-only reload and a guarded preload from an unguarded one. Pin pulses under each edge setting, with prescaler pulses sent to the unselected source, separate the edge choices and show that the tick source is selected correctly.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_MOD   = 2'd1,
      REG_FLAG  = 2'd2,
      REG_LOAD  = 2'd3
   } reg_sel_e;

   // bit4 run, bit3 rising edge, bit2 both edges, bit1 external source, bit0 up/down
   typedef struct packed {
      logic run;
      logic edge_rise;
      logic edge_both;
      logic ext_src;
      logic updown;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mcc_edge_sync.sv
module mcc_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic edge_rise,
   input  logic edge_both,
   output logic tick
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("mcc_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q[i] <= 1'b0;
            else if (i == 0)
               sync_q[i] <= pin;
            else
               sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   logic rise, fall;
   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;
   assign tick = edge_both ? (rise | fall) : (edge_rise ? rise : fall);

   // R7: a single-edge setting gives one-cycle pulses
   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !edge_both && $stable(edge_rise) && $stable(edge_both)) |=> !tick || edge_both || !$stable(edge_rise));

endmodule

// File: rtl/mcc_modulus_reg.sv
module mcc_modulus_reg #(
   parameter int              CNT_W     = 16,
   parameter logic [CNT_W-1:0] RESET_MOD = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_wr,
   input  logic [CNT_W-1:0] buf_data,
   input  logic             run,
   input  logic             boundary,
   output logic [CNT_W-1:0] active_mod
);
   logic [CNT_W-1:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      buf_q <= RESET_MOD;
      else if (buf_wr) buf_q <= buf_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 active_mod <= RESET_MOD;
      else if (!run || boundary)  active_mod <= buf_q;
   end

   // R4: no reload in the middle of a running cycle
   assert_hold_mid_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !boundary) |=> $stable(active_mod));

endmodule

// File: rtl/mcc_count_core.sv
module mcc_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             updown,
   input  logic             tick,
   input  logic [CNT_W-1:0] modulus,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_data,
   output logic [CNT_W-1:0] count,
   output logic             boundary
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
   localparam logic [CNT_W-1:0] ALL_1 = '1;

   logic             dir_up_q, dir_up_d;
   logic [CNT_W-1:0] count_d;

   always_comb begin
      count_d  = count;
      dir_up_d = dir_up_q;
      boundary = 1'b0;
      if (!run) begin
         dir_up_d = 1'b1;
         if (load_wr) count_d = load_data;
      end else if (tick) begin
         if (!updown) begin
            dir_up_d = 1'b1;
            if (count == modulus) begin
               count_d  = ONE;
               boundary = 1'b1;
            end else if (count == ALL_1) begin
               count_d = ONE;
            end else begin
               count_d = count + ONE;
            end
         end else if (dir_up_q) begin
            if (count == modulus) begin
               count_d  = count - ONE;
               dir_up_d = 1'b0;
               boundary = (count == TWO);
            end else if (count == ALL_1) begin
               count_d = ONE;
            end else begin
               count_d = count + ONE;
            end
         end else begin
            if (count <= ONE) begin
               count_d  = TWO;
               dir_up_d = 1'b1;
            end else begin
               count_d  = count - ONE;
               boundary = (count == TWO);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= ONE;
         dir_up_q <= 1'b1;
      end else begin
         count    <= count_d;
         dir_up_q <= dir_up_d;
      end
   end

   assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(count));
   assert_never_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && count != '0) |=> (count != '0));
   assert_up_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !updown && count == modulus) |=> (count == ONE));
   assert_turn_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && updown && dir_up_q && count == modulus) |=> !dir_up_q);
   assert_allones_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && dir_up_q && count == ALL_1 && count != modulus) |=> (count == ONE));
   assert_preload_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && load_wr && !tick) |=> $stable(count));

endmodule

// File: rtl/mcc_channel.sv
module mcc_channel
   import mcc_pkg::*;
#(
   parameter int               CNT_W       = 16,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] RESET_MOD   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             presc_tick,
   input  logic             ext_pin,
   output logic [CNT_W-1:0] count_o,
   output logic             flag_o
);
   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("mcc_channel: CNT_W must be at least 8");
      end
      if (RESET_MOD < 2) begin : g_bad_mod
         $error("mcc_channel: RESET_MOD must exceed 1");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic             ext_tick, tick, boundary, flag_clr;
   logic [CNT_W-1:0] modulus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en && wr_addr == REG_CTRL)
         ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   mcc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_pin),
      .edge_rise (ctrl_q.edge_rise),
      .edge_both (ctrl_q.edge_both),
      .tick      (ext_tick)
   );

   assign tick = ctrl_q.ext_src ? ext_tick : presc_tick;

   mcc_modulus_reg #(.CNT_W(CNT_W), .RESET_MOD(RESET_MOD)) u_mod (
      .clk        (clk),
      .rst_n      (rst_n),
      .buf_wr     (wr_en && wr_addr == REG_MOD),
      .buf_data   (wr_data),
      .run        (ctrl_q.run),
      .boundary   (boundary),
      .active_mod (modulus)
   );

   mcc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl_q.run),
      .updown    (ctrl_q.updown),
      .tick      (tick),
      .modulus   (modulus),
      .load_wr   (wr_en && wr_addr == REG_LOAD),
      .load_data (wr_data),
      .count     (count_o),
      .boundary  (boundary)
   );

   assign flag_clr = wr_en && wr_addr == REG_FLAG && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o <= 1'b0;
      else if (boundary) flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
   end

   assert_flag_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> flag_o);
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !flag_clr) |=> flag_o);
   assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !boundary) |=> !flag_o);

endmodule

// File: tb/tb_mcc_channel.sv
module tb_mcc_channel;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         presc_tick = 1'b0;
   logic         ext_pin = 1'b0;
   logic [W-1:0] count_o;
   logic         flag_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // control encodings
   localparam logic [W-1:0] C_RUN  = 16'h0010;
   localparam logic [W-1:0] C_RISE = 16'h0008;
   localparam logic [W-1:0] C_BOTH = 16'h0004;
   localparam logic [W-1:0] C_EXT  = 16'h0002;
   localparam logic [W-1:0] C_UD   = 16'h0001;

   mcc_channel dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .presc_tick(presc_tick), .ext_pin(ext_pin),
      .count_o(count_o), .flag_o(flag_o)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         presc_tick = 1'b1;
         @(negedge clk);
      end
      presc_tick = 1'b0;
   endtask

   task automatic pin_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ext_pin = 1'b1;
         repeat (5) @(negedge clk);
         ext_pin = 1'b0;
         repeat (5) @(negedge clk);
      end
   endtask

   // stop, set the modulus and the counter, then start
   task automatic setup(input logic [W-1:0] m, input logic [W-1:0] c, input logic [W-1:0] ctl);
      wr(2'd0, '0);
      wr(2'd1, m);
      wr(2'd3, c);
      wr(2'd2, 16'h1);
      wr(2'd0, ctl);
   endtask

   task automatic t_reset;
      check("R11 count", int'(count_o), 1);
      check("R11 flag", int'(flag_o), 0);
   endtask

   task automatic t_up;
      setup(16'd4, 16'd1, C_RUN);
      check("R1 no tick holds", int'(count_o), 1);
      ticks(3);
      check("R2 at modulus", int'(count_o), 4);
      check("R8 no early flag", int'(flag_o), 0);
      ticks(1);
      check("R2 restart", int'(count_o), 1);
      check("R8 flag at boundary", int'(flag_o), 1);
      wr(2'd2, 16'h0);
      check("R9 write 0 keeps flag", int'(flag_o), 1);
      wr(2'd2, 16'h1);
      check("R9 clear", int'(flag_o), 0);
      ticks(4);
      check("R2 second period", int'(count_o), 1);
      check("R8 second flag", int'(flag_o), 1);
      wr(2'd2, 16'h1);
      ticks(3);
      presc_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h1;
      @(negedge clk);
      presc_tick = 1'b0; wr_en = 1'b0;
      check("R9 set wins", int'(flag_o), 1);
   endtask

   task automatic t_reload;
      setup(16'd4, 16'd1, C_RUN);
      ticks(1);
      wr(2'd1, 16'd6);
      ticks(2);
      check("R4 old modulus kept", int'(count_o), 4);
      ticks(1);
      check("R4 restart at old modulus", int'(count_o), 1);
      ticks(5);
      check("R4 new modulus reached", int'(count_o), 6);
      ticks(1);
      check("R4 restart at new modulus", int'(count_o), 1);
   endtask

   task automatic t_updown;
      int exp_c;
      int up;
      setup(16'd3, 16'd1, C_RUN | C_UD);
      exp_c = 1; up = 1;
      for (int i = 0; i < 8; i++) begin
         if (up != 0) begin
            if (exp_c == 3) begin exp_c = 2; up = 0; end
            else exp_c = exp_c + 1;
         end else begin
            if (exp_c == 1) begin exp_c = 2; up = 1; end
            else exp_c = exp_c - 1;
         end
         ticks(1);
         check("R3 up/down step", int'(count_o), exp_c);
         if (i == 2) check("R8 no flag before down to 1", int'(flag_o), 0);
         if (i == 3) begin
            check("R8 flag at down to 1", int'(flag_o), 1);
            wr(2'd2, 16'h1);
         end
      end
      check("R3 period 4 flag", int'(flag_o), 1);
   endtask

   task automatic t_out_of_range;
      setup(16'd5, 16'hFFF0, C_RUN);
      ticks(15);
      check("R5 reaches all-ones", int'(count_o), 16'hFFFF);
      ticks(1);
      check("R5 wraps to 1", int'(count_o), 1);
      check("R5 no flag on wrap", int'(flag_o), 0);
      ticks(4);
      check("R5 normal at modulus", int'(count_o), 5);
      ticks(1);
      check("R5 normal restart flag", int'(flag_o), 1);
   endtask

   task automatic t_preload;
      setup(16'd9, 16'd1, C_RUN);
      ticks(2);
      wr(2'd3, 16'd7);
      check("R10 preload ignored while running", int'(count_o), 3);
      wr(2'd0, '0);
      wr(2'd3, 16'd7);
      check("R10 preload while stopped", int'(count_o), 7);
   endtask

   task automatic t_ext;
      setup(16'hFFFF, 16'd1, C_RUN | C_EXT | C_RISE);
      ticks(3);
      check("R6 prescaler ignored", int'(count_o), 1);
      pin_pulses(3);
      check("R7 rising edges", int'(count_o), 4);
      wr(2'd0, C_RUN | C_EXT);
      pin_pulses(2);
      check("R7 falling edges", int'(count_o), 6);
      wr(2'd0, C_RUN | C_EXT | C_BOTH);
      pin_pulses(2);
      check("R7 both edges", int'(count_o), 10);
      wr(2'd0, C_RUN);
      pin_pulses(2);
      check("R6 pin ignored when internal", int'(count_o), 10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_up();
      t_reload();
      t_updown();
      t_out_of_range();
      t_preload();
      t_ext();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule